// File: doc/BRIEF.md
# Aperture Page Remapper

This block translates bus addresses that fall inside a fixed aperture into physical addresses through a flat, single-level page table. The pages are 4 KiB. Each table slot is one 32-bit word. Bit 31 of the word marks the slot as valid, and bits [30:12] hold the physical page base. The 12-bit page offset passes through unchanged. An all-zero word is an unmapped slot.

A host configures the block through three 32-bit registers:
- offset 0x0 holds the global enable in bit 0;
- offset 0x4 is the slot-select register, which holds an aperture address;
- offset 0x8 is the slot-data window.

The host reaches a slot only indirectly. It first writes an aperture address to 0x4, then reads or writes 0x8. A write to 0x8 commits the slot.

A separate lookup port accepts one address per cycle with a valid/ready handshake. It returns a registered result one cycle later: the translated address and a hit flag, or a fault flag. A fault is raised when translation is disabled, when the address lies outside the aperture, or when the selected slot is invalid.

Top module: `aperture_remap`

## Requirements
- R1: After reset every slot reads zero, the enable register reads zero, and lookups fault.
- R2: A write to offset 0x0 sets the enable from bit 0 of the written data. A read of 0x0 returns the enable in bit 0 and zeros in every other bit.
- R3: A read of offset 0x4 returns the last value written to it, in full.
- R4: A write to offset 0x8 stores the data in slot (select − base) >> 12, provided the select register lies inside the aperture.
- R5: A read of offset 0x8 returns the slot chosen by the select register. If the select lies outside the aperture, the read returns zero and a write to 0x8 changes no slot.
- R6: A lookup that hits returns hit=1, fault=0 and address {1'b0, slot[30:12], addr[11:0]}. The result appears on res_valid one cycle after acceptance.
- R7: While the enable is 0, every lookup returns fault=1.
- R8: An address below base, or above base + PAGES×4096 − 1, faults. The last byte of the final page still hits.
- R9: A lookup to a slot with bit 31 clear faults. Every faulting result carries address zero.
- R10: lk_ready is low while a result is held with res_ready low. A held result stays stable until it is taken.
- R11: A lookup accepted in the same cycle as a slot write sees the old slot value. A lookup accepted in the next cycle sees the new value.
- R12: A register read returns data with host_rvalid one cycle after the request. Offsets other than 0x0, 0x4 and 0x8 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Register access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_off | input | 4 | Register byte offset |
| host_wdata | input | 32 | Write data |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 32 | Read data |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted |
| lk_addr | input | 32 | Address to translate |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumed |
| res_addr | output | 32 | Translated address, zero on fault |
| res_hit | output | 1 | Translation succeeded |
| res_fault | output | 1 | Translation failed |

## Verification
On every cycle, the assertions check the following:
- hit and fault are exclusive on each result, and a fault carries address zero;
- the page offset survives translation;
- a held result stays stable under back-pressure;
- a disabled block or an out-of-aperture address always faults;
- a read request is answered one cycle later.

Slot contents can only be shown by the bench's scenarios, because checking them needs a known table:
- the correct physical base is returned and bit 31 is masked;
- an out-of-range slot write is dropped;
- the old-versus-new ordering holds when a write and a lookup share a cycle.

// File: rtl/aperture_remap.sv
module aperture_remap #(
  parameter logic [31:0] APT_BASE = 32'h5800_0000,
  parameter int          PAGES    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_we,
  input  logic [3:0]  host_off,
  input  logic [31:0] host_wdata,
  output logic        host_rvalid,
  output logic [31:0] host_rdata,
  input  logic        lk_valid,
  output logic        lk_ready,
  input  logic [31:0] lk_addr,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [31:0] res_addr,
  output logic        res_hit,
  output logic        res_fault
);
  localparam int          PG      = 12;
  localparam int          IDX_W   = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam logic [31:0] PAGES_W = 32'(PAGES);
  localparam logic [3:0]  OFF_CFG = 4'h0;
  localparam logic [3:0]  OFF_SEL = 4'h4;
  localparam logic [3:0]  OFF_DAT = 4'h8;

  logic             cfg_en;
  logic [31:0]      sel_q;
  logic [31:0]      tbl [PAGES];

  logic [31:0]      sel_rel, lk_rel, lk_ent, rd_mux;
  logic             sel_in, lk_in, lk_hit;
  logic [IDX_W-1:0] sel_idx, lk_idx;
  logic             wr_cfg, wr_sel, wr_dat, rd_req, take;

  assign sel_rel = sel_q - APT_BASE;
  assign sel_in  = (sel_q >= APT_BASE) && ({12'h0, sel_rel[31:PG]} < PAGES_W);
  assign sel_idx = sel_rel[PG +: IDX_W];

  assign lk_rel  = lk_addr - APT_BASE;
  assign lk_in   = (lk_addr >= APT_BASE) && ({12'h0, lk_rel[31:PG]} < PAGES_W);
  assign lk_idx  = lk_rel[PG +: IDX_W];
  assign lk_ent  = lk_in ? tbl[lk_idx] : '0;
  assign lk_hit  = cfg_en && lk_in && lk_ent[31];

  assign wr_cfg  = host_req && host_we && (host_off == OFF_CFG);
  assign wr_sel  = host_req && host_we && (host_off == OFF_SEL);
  assign wr_dat  = host_req && host_we && (host_off == OFF_DAT);
  assign rd_req  = host_req && !host_we;

  assign lk_ready = !res_valid || res_ready;
  assign take     = lk_valid && lk_ready;

  always_comb begin
    case (host_off)
      OFF_CFG: rd_mux = {31'b0, cfg_en};
      OFF_SEL: rd_mux = sel_q;
      OFF_DAT: rd_mux = sel_in ? tbl[sel_idx] : '0;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_en <= 1'b0;
      sel_q  <= '0;
    end else begin
      if (wr_cfg) cfg_en <= host_wdata[0];
      if (wr_sel) sel_q  <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGES; i++) tbl[i] <= '0;
    end else if (wr_dat && sel_in) begin
      tbl[sel_idx] <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rd_req;
      if (rd_req) host_rdata <= rd_mux;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_addr  <= '0;
      res_hit   <= 1'b0;
      res_fault <= 1'b0;
    end else if (take) begin
      res_valid <= 1'b1;
      res_hit   <= lk_hit;
      res_fault <= !lk_hit;
      res_addr  <= lk_hit ? {1'b0, lk_ent[30:PG], lk_addr[PG-1:0]} : '0;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/aperture_remap_chk.sv
module aperture_remap_chk #(
  parameter logic [31:0] APT_BASE = 32'h5800_0000,
  parameter int          PAGES    = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_req,
  input logic        host_we,
  input logic        host_rvalid,
  input logic        lk_valid,
  input logic        lk_ready,
  input logic [31:0] lk_addr,
  input logic        res_valid,
  input logic        res_ready,
  input logic [31:0] res_addr,
  input logic        res_hit,
  input logic        res_fault,
  input logic        cfg_en
);
  localparam logic [31:0] APT_LAST = APT_BASE + 32'(PAGES) * 32'd4096 - 32'd1;

  assert_hit_xor_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit ^ res_fault));

  assert_offset_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> (res_fault || (res_addr[11:0] == $past(lk_addr[11:0]))));

  assert_disabled_faults_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && !cfg_en) |=> (res_valid && res_fault));

  assert_outside_faults_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && ((lk_addr < APT_BASE) || (lk_addr > APT_LAST))) |=> res_fault);

  assert_fault_zero_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> (res_addr == 32'h0));

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_addr) && $stable(res_hit)));

  assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we) |=> host_rvalid);
endmodule

bind aperture_remap aperture_remap_chk #(.APT_BASE(APT_BASE), .PAGES(PAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
  .host_rvalid(host_rvalid), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .lk_addr(lk_addr), .res_valid(res_valid), .res_ready(res_ready),
  .res_addr(res_addr), .res_hit(res_hit), .res_fault(res_fault), .cfg_en(cfg_en)
);

// File: tb/aperture_remap_tb.sv
`timescale 1ns/1ps
module aperture_remap_tb;
  localparam logic [31:0] BASE = 32'h5800_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [3:0]  host_off = '0;
  logic [31:0] host_wdata = '0;
  logic        host_rvalid;
  logic [31:0] host_rdata;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_addr = '0;
  logic        res_valid, res_ready = 1'b1;
  logic [31:0] res_addr;
  logic        res_hit, res_fault;

  int compared = 0, mismatched = 0;
  logic [32:0] exp_q [$];
  string       tag_q [$];
  bit          done = 1'b0;

  always #4 clk = ~clk;

  aperture_remap #(.APT_BASE(BASE), .PAGES(16)) u_dut (.*);

  task automatic check(input logic [32:0] act, input logic [32:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic hwrite(input logic [3:0] off, input logic [31:0] d);
    host_req = 1'b1; host_we = 1'b1; host_off = off; host_wdata = d;
    @(posedge clk); #1;
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic hread(input logic [3:0] off, input logic [31:0] exp, input string tag);
    host_req = 1'b1; host_we = 1'b0; host_off = off;
    @(posedge clk); #1;
    host_req = 1'b0;
    check({host_rvalid, host_rdata}, {1'b1, exp}, tag);
  endtask

  task automatic lookup(input logic [31:0] a, input logic hit, input logic [31:0] pa, input string tag);
    logic r;
    lk_valid = 1'b1; lk_addr = a;
    exp_q.push_back({hit, pa}); tag_q.push_back(tag);
    do begin
      @(negedge clk); r = lk_ready;
      @(posedge clk); #1;
    end while (!r);
    lk_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (exp_q.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R10: actual unexpected result %h expected none", res_addr);
      end else begin
        string t;
        logic [32:0] e;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check({res_hit, res_addr}, e, t);
        check({31'b0, res_fault}, {32'b0, ~e[32]}, {t, " fault flag"});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;

    hread(4'h0, 32'h0, "R1 enable after reset");
    hwrite(4'h4, BASE + 32'h3000);
    hread(4'h8, 32'h0, "R1 slot after reset");
    lookup(BASE + 32'h3010, 1'b0, 32'h0, "R1 lookup after reset");

    hwrite(4'h0, 32'h0000_0007);
    hread(4'h0, 32'h1, "R2 enable readback");
    hwrite(4'h4, BASE + 32'h0abc);
    hread(4'h4, BASE + 32'h0abc, "R3 select readback");
    hread(4'hC, 32'h0, "R12 unknown offset");

    hwrite(4'h8, 32'h8001_2000);
    hread(4'h8, 32'h8001_2000, "R4 slot0 readback");
    lookup(BASE + 32'h0123, 1'b1, 32'h0001_2123, "R6 hit slot0");

    hwrite(4'h4, BASE + 32'hF000);
    hwrite(4'h8, 32'hFFFF_F000);
    lookup(BASE + 32'hFFFF, 1'b1, 32'h7FFF_FFFF, "R8 last byte hits");
    lookup(BASE + 32'h1_0000, 1'b0, 32'h0, "R8 past end faults");
    lookup(BASE - 32'h1, 1'b0, 32'h0, "R8 below base faults");

    hwrite(4'h4, BASE + 32'h5000);
    hwrite(4'h8, 32'h0000_5000);
    lookup(BASE + 32'h5010, 1'b0, 32'h0, "R9 invalid slot faults");

    hwrite(4'h4, BASE + 32'h1_0000);
    hwrite(4'h8, 32'h8003_3000);
    hread(4'h8, 32'h0, "R5 out-of-range read zero");
    hwrite(4'h4, BASE);
    hread(4'h8, 32'h8001_2000, "R5 out-of-range write ignored");
    lookup(BASE + 32'h0040, 1'b1, 32'h0001_2040, "R5 slot0 unchanged");

    hwrite(4'h0, 32'h0);
    lookup(BASE + 32'h0123, 1'b0, 32'h0, "R7 disabled faults");
    hwrite(4'h0, 32'h1);

    // R11: same-cycle write and lookup
    hwrite(4'h4, BASE + 32'h2000);
    hwrite(4'h8, 32'h8000_7000);
    repeat (2) @(posedge clk); #1;
    host_req = 1'b1; host_we = 1'b1; host_off = 4'h8; host_wdata = 32'h8000_9000;
    lk_valid = 1'b1; lk_addr = BASE + 32'h2abc;
    exp_q.push_back({1'b1, 32'h0000_7abc}); tag_q.push_back("R11 old value same cycle");
    @(posedge clk); #1;
    host_req = 1'b0; host_we = 1'b0; lk_valid = 1'b0;
    lookup(BASE + 32'h2abc, 1'b1, 32'h0000_9abc, "R11 new value next cycle");

    // R10: back-pressure
    repeat (2) @(posedge clk); #1;
    res_ready = 1'b0;
    lookup(BASE + 32'h0777, 1'b1, 32'h0001_2777, "R10 held result");
    held = res_addr;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check({32'b0, lk_ready}, 33'h0, "R10 ready low while held");
      check({res_valid, res_addr}, {1'b1, held}, "R10 result stable");
    end
    @(posedge clk); #1;
    res_ready = 1'b1;

    repeat (4) @(posedge clk);
    check({1'b0, 32'(exp_q.size())}, 33'h0, "R6 all results returned");
    done = 1'b1;
    summary();
  end
endmodule